// File: doc/BRIEF.md
# Fractional-N PLL Output Rate Calculator

This block works out the output frequency of a fractional-N PLL from the three packed control words that program the PLL and from the reference frequency. A start strobe captures the reference rate and the words. The block then unpacks five fields from the words: the integer multiplier, the fractional numerator, the fractional denominator, the pre-divider code and the output divider code.

The decoded fields are first compared against a built-in table of eight known settings. An exact match returns that entry's rated frequency directly. When nothing matches, the block evaluates the fractional equation. It builds a 64-bit dividend and a 32-bit divisor product, then runs a restoring shift-subtract division that produces one quotient bit per clock.

A divisor product of zero ends the calculation at once, returns zero and raises an error flag. The result comes back with a one-cycle done pulse and is held until the next calculation. Start requests that arrive while a calculation runs are dropped.

Top module: `fracn_rate_calc`

## Requirements
- R1: Field positions. The fractional numerator is numWord[31:2]. The denominator is denWord[29:0]. In divWord, the integer multiplier is bits 24:16, the pre-divider code is bits 15:13 and the output divider code is bits 7:0. All other bits of the three words have no effect on the result.
- R2: With no table match, rateOut = (ref*mfi*mfd + ref*mfn) / (mfd*pre*post). The dividend wraps at 64 bits, the divisor product wraps at 32 bits, and the quotient is truncated.
- R3: A pre-divider code of 0 divides by 1; codes 1..7 divide by their own value.
- R4: An output divider code of 0 divides by 2 and a code of 1 divides by 3; codes 2..255 divide by their own value.
- R5: The raw decoded codes (mfi, mfn, mfd, pre code, post code) are matched exactly against eight presets, and a match returns the preset rate regardless of the reference. The presets include 650000000 (162, 50, 100, 0, 6) and 400000000 (200, 0, 1, 0, 12).
- R6: done is high for exactly one cycle. Counting the clock edge that accepts start as edge 1, done is visible after edge 2 for a preset match or a zero divisor, and after edge 66 for a computed rate.
- R7: A zero divisor product, including one that wraps to zero, gives rateOut = 0 and divErr = 1. divErr clears when the next start is accepted.
- R8: busy is high from the edge after start is accepted until done. A start while busy is ignored: it neither changes the running result nor causes a second done.
- R9: After reset, busy, done, divErr and rateOut are all zero.
- R10: rateOut changes only in the cycle where done is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (accepted when not busy) |
| refRate | input | 64 | Reference frequency in Hz |
| numWord | input | 32 | Packed fractional-numerator word |
| denWord | input | 32 | Packed fractional-denominator word |
| divWord | input | 32 | Packed multiplier/divider word |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| rateOut | output | 64 | Computed or preset output rate in Hz |
| divErr | output | 1 | Divisor product was zero |

## Verification
A preset match or a zero divisor produces done after the second edge from start acceptance, and a computed rate produces it after the 66th. The bench counts edges from the accepting edge and samples at falling edges. It checks the measured latency against the expected value for the path the inputs should take, then samples rateOut and divErr in the done cycle. One further falling-edge sample confirms that done has dropped. For the busy-ignore case, the bench watches for a full extra division period to confirm that no second done appears.

// File: rtl/fracn_rate_pkg.sv
package fracn_rate_pkg;

  localparam int RATE_W   = 64;
  localparam int DIVSR_W  = 32;
  localparam int MFI_W    = 9;
  localparam int MFN_W    = 30;
  localparam int MFD_W    = 30;
  localparam int PRE_W    = 3;
  localparam int POST_W   = 8;
  localparam int N_PRESET = 8;

  localparam int MFN_LSB  = 2;
  localparam int MFD_LSB  = 0;
  localparam int MFI_LSB  = 16;
  localparam int PRE_LSB  = 13;
  localparam int POST_LSB = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_DIV} calcState_t;

  typedef struct packed {
    logic capture;
    logic loadDiv;
    logic stepDiv;
    logic finHit;
    logic finErr;
    logic finDiv;
  } calcStrobe_t;

  typedef struct packed {
    logic [MFI_W-1:0]  mfi;
    logic [MFN_W-1:0]  mfn;
    logic [MFD_W-1:0]  mfd;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } fieldKey_t;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    fieldKey_t         key;
  } presetEntry_t;

  function automatic presetEntry_t mkEntry(input longint unsigned r, input int mi, input int mn,
                                           input int md, input int pr, input int po);
    presetEntry_t e;
    e.rate     = RATE_W'(r);
    e.key.mfi  = MFI_W'(mi);
    e.key.mfn  = MFN_W'(mn);
    e.key.mfd  = MFD_W'(md);
    e.key.pre  = PRE_W'(pr);
    e.key.post = POST_W'(po);
    return e;
  endfunction

  function automatic presetEntry_t presetEntry(input int idx);
    case (idx)
      0:       return mkEntry(64'd650000000, 162, 50, 100, 0, 6);
      1:       return mkEntry(64'd594000000, 198, 0, 1, 0, 8);
      2:       return mkEntry(64'd560000000, 140, 0, 1, 0, 6);
      3:       return mkEntry(64'd498000000, 166, 0, 1, 0, 8);
      4:       return mkEntry(64'd484000000, 121, 0, 1, 0, 6);
      5:       return mkEntry(64'd445333333, 167, 0, 1, 0, 9);
      6:       return mkEntry(64'd400000000, 200, 0, 1, 0, 12);
      default: return mkEntry(64'd393216000, 163, 84, 100, 0, 10);
    endcase
  endfunction

endpackage

// File: rtl/fracn_rate_ctrl.sv
module fracn_rate_ctrl
  import fracn_rate_pkg::*;
#(
  parameter int QUOT_W = RATE_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        presetHit,
  input  logic        divZero,
  output calcStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(QUOT_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(QUOT_W - 1);

  calcState_t stateQ, stateD;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (presetHit) begin
          strobe.finHit = 1'b1;
          stateD = ST_IDLE;
        end else if (divZero) begin
          strobe.finErr = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobe.loadDiv = 1'b1;
          stateD = ST_DIV;
        end
      end
      ST_DIV: begin
        strobe.stepDiv = 1'b1;
        if (stepCnt == LAST_STEP) begin
          strobe.finDiv = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strobe.finHit | strobe.finErr | strobe.finDiv;
      if (strobe.loadDiv)      stepCnt <= '0;
      else if (strobe.stepDiv) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/fracn_rate_dp.sv
module fracn_rate_dp
  import fracn_rate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  calcStrobe_t         strobe,
  input  logic [RATE_W-1:0]   refRate,
  input  logic [31:0]         numWord,
  input  logic [31:0]         denWord,
  input  logic [31:0]         divWord,
  output logic                presetHit,
  output logic                divZero,
  output logic [RATE_W-1:0]   rateOut,
  output logic                divErr
);

  logic [RATE_W-1:0] refQ;
  logic [31:0]       numQ, denQ, divQ;
  fieldKey_t         key;
  logic [DIVSR_W-1:0] preEff, postEff, divisor;
  logic [RATE_W-1:0]  dividend;
  logic [N_PRESET-1:0] matchVec;
  logic [RATE_W-1:0]  presetRate;

  logic [RATE_W-1:0]  quotQ, quotNext;
  logic [DIVSR_W-1:0] remQ, remNext, dvsrQ;
  logic [DIVSR_W:0]   remShift, remDiff;

  // field unpacking
  assign key.mfn  = numQ[MFN_LSB +: MFN_W];
  assign key.mfd  = denQ[MFD_LSB +: MFD_W];
  assign key.mfi  = divQ[MFI_LSB +: MFI_W];
  assign key.pre  = divQ[PRE_LSB +: PRE_W];
  assign key.post = divQ[POST_LSB +: POST_W];

  // non-linear divider encodings
  assign preEff = (key.pre == '0) ? DIVSR_W'(1) : DIVSR_W'(key.pre);
  always_comb begin
    case (key.post)
      POST_W'(0): postEff = DIVSR_W'(2);
      POST_W'(1): postEff = DIVSR_W'(3);
      default:    postEff = DIVSR_W'(key.post);
    endcase
  end

  assign dividend = refQ * RATE_W'(key.mfi) * RATE_W'(key.mfd) + refQ * RATE_W'(key.mfn);
  assign divisor  = DIVSR_W'(key.mfd) * preEff * postEff;
  assign divZero  = (divisor == '0);

  // preset comparison
  for (genvar i = 0; i < N_PRESET; i++) begin : g_match
    assign matchVec[i] = (key == presetEntry(i).key);
  end

  always_comb begin
    presetRate = '0;
    for (int i = N_PRESET - 1; i >= 0; i--) begin
      if (matchVec[i]) presetRate = presetEntry(i).rate;
    end
  end
  assign presetHit = |matchVec;

  // restoring division, one quotient bit per step
  assign remShift = {remQ, quotQ[RATE_W-1]};
  assign remDiff  = remShift - {1'b0, dvsrQ};
  always_comb begin
    if (!remDiff[DIVSR_W]) begin
      remNext  = remDiff[DIVSR_W-1:0];
      quotNext = {quotQ[RATE_W-2:0], 1'b1};
    end else begin
      remNext  = remShift[DIVSR_W-1:0];
      quotNext = {quotQ[RATE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ    <= '0;
      numQ    <= '0;
      denQ    <= '0;
      divQ    <= '0;
      quotQ   <= '0;
      remQ    <= '0;
      dvsrQ   <= '0;
      rateOut <= '0;
      divErr  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        refQ   <= refRate;
        numQ   <= numWord;
        denQ   <= denWord;
        divQ   <= divWord;
        divErr <= 1'b0;
      end
      if (strobe.loadDiv) begin
        quotQ <= dividend;
        remQ  <= '0;
        dvsrQ <= divisor;
      end else if (strobe.stepDiv) begin
        quotQ <= quotNext;
        remQ  <= remNext;
      end
      if (strobe.finHit) rateOut <= presetRate;
      if (strobe.finErr) begin
        rateOut <= '0;
        divErr  <= 1'b1;
      end
      if (strobe.finDiv) rateOut <= quotNext;
    end
  end

endmodule

// File: rtl/fracn_rate_calc.sv
module fracn_rate_calc
  import fracn_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [63:0]       refRate,
  input  logic [31:0]       numWord,
  input  logic [31:0]       denWord,
  input  logic [31:0]       divWord,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rateOut,
  output logic              divErr
);

  calcStrobe_t strobe;
  logic presetHit, divZero;

  fracn_rate_ctrl #(.QUOT_W(RATE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .presetHit (presetHit),
    .divZero   (divZero),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  fracn_rate_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .refRate   (refRate),
    .numWord   (numWord),
    .denWord   (denWord),
    .divWord   (divWord),
    .presetHit (presetHit),
    .divZero   (divZero),
    .rateOut   (rateOut),
    .divErr    (divErr)
  );

endmodule

// File: rtl/fracn_rate_chk.sv
module fracn_rate_chk #(
  parameter int MAX_BUSY = 65
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [63:0] rateOut,
  input logic        divErr
);

  logic [7:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R6: no calculation stays busy longer than the division path
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN) busyRun <= 8'(MAX_BUSY));

  // R8: an idle start is accepted on the next edge
  p_start_accept_r8: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy);

  // R8: the block is idle in the result cycle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R7: error always reports a zero rate
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rstN) divErr |-> (rateOut == 64'd0));

  // R7: error rises only with a result
  p_err_rise_r7: assert property (@(posedge clk) disable iff (!rstN) $rose(divErr) |-> done);

  // R10: result changes only with done
  p_rate_hold_r10: assert property (@(posedge clk) disable iff (!rstN) !$stable(rateOut) |-> done);

endmodule

bind fracn_rate_calc fracn_rate_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .rateOut (rateOut),
  .divErr  (divErr)
);

// File: tb/fracn_rate_calc_tb.sv
module fracn_rate_calc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] refRate = '0;
  logic [31:0] numWord = '0, denWord = '0, divWord = '0;
  logic        busy, done, divErr;
  logic [63:0] rateOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam int LAT_SHORT = 2;
  localparam int LAT_LONG  = 66;

  fracn_rate_calc u_dut (
    .clk(clk), .rstN(rstN), .start(start), .refRate(refRate),
    .numWord(numWord), .denWord(denWord), .divWord(divWord),
    .busy(busy), .done(done), .rateOut(rateOut), .divErr(divErr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] packNum(input logic [29:0] mfn);
    return {mfn, 2'b00};
  endfunction
  function automatic logic [31:0] packDen(input logic [29:0] mfd);
    return {2'b00, mfd};
  endfunction
  function automatic logic [31:0] packDiv(input logic [8:0] mfi, input logic [2:0] pre, input logic [7:0] post);
    return {7'b0, mfi, pre, 5'b0, post};
  endfunction

  // model of R2/R3/R4 from the requirement text
  function automatic logic [63:0] model(input logic [63:0] r, input logic [8:0] mfi, input logic [29:0] mfn,
                                        input logic [29:0] mfd, input logic [2:0] pre, input logic [7:0] post);
    logic [63:0] n;
    logic [31:0] d, pe, po;
    pe = (pre == 0) ? 32'd1 : {29'd0, pre};
    po = (post == 0) ? 32'd2 : (post == 1) ? 32'd3 : {24'd0, post};
    n  = r * {55'd0, mfi} * {34'd0, mfd} + r * {34'd0, mfn};
    d  = {2'b0, mfd} * pe * po;
    return n / {32'd0, d};
  endfunction

  logic [63:0] gotRate;
  logic        gotErr, doneAfter, busyAfterAccept;
  int          gotLat;

  task automatic runCalc(input logic [63:0] r, input logic [31:0] nw, input logic [31:0] dw, input logic [31:0] vw);
    @(negedge clk);
    refRate = r; numWord = nw; denWord = dw; divWord = vw; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busyAfterAccept = busy;
    gotLat = 1;
    while (!done && gotLat < 200) begin
      @(posedge clk);
      @(negedge clk);
      gotLat++;
    end
    gotRate = rateOut;
    gotErr  = divErr;
    @(posedge clk);
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic t_reset();
    check("R9 busy", {63'd0, busy}, 64'd0);
    check("R9 done", {63'd0, done}, 64'd0);
    check("R9 err", {63'd0, divErr}, 64'd0);
    check("R9 rate", rateOut, 64'd0);
  endtask

  task automatic t_preset650();
    runCalc(64'd25000000, packNum(30'd50), packDen(30'd100), packDiv(9'd162, 3'd0, 8'd6));
    check("R5 preset 650", gotRate, 64'd650000000);
    check("R6 preset latency", 64'(gotLat), 64'(LAT_SHORT));
    check("R6 done pulse", {63'd0, doneAfter}, 64'd0);
    check("R8 busy after accept", {63'd0, busyAfterAccept}, 64'd1);
    check("R10 rate held", rateOut, 64'd650000000);
  endtask

  task automatic t_preset400();
    runCalc(64'd0, packNum(30'd0), packDen(30'd1), packDiv(9'd200, 3'd0, 8'd12));
    check("R5 preset 400", gotRate, 64'd400000000);
    check("R5 no err", {63'd0, gotErr}, 64'd0);
  endtask

  task automatic t_defaults();
    runCalc(64'd24000000, packNum(30'd0), packDen(30'd1), packDiv(9'd100, 3'd0, 8'd0));
    check("R3 R4 pre0 post0", gotRate, 64'd1200000000);
    check("R6 compute latency", 64'(gotLat), 64'(LAT_LONG));
    check("R6 done pulse long", {63'd0, doneAfter}, 64'd0);
  endtask

  task automatic t_post1();
    runCalc(64'd24000000, packNum(30'd0), packDen(30'd1), packDiv(9'd150, 3'd2, 8'd1));
    check("R4 post code 1", gotRate, 64'd600000000);
  endtask

  task automatic t_fraction();
    runCalc(64'd24000000, packNum(30'd84), packDen(30'd100), packDiv(9'd163, 3'd0, 8'd11));
    check("R2 fractional", gotRate, model(64'd24000000, 9'd163, 30'd84, 30'd100, 3'd0, 8'd11));
    runCalc(64'd24000000, packNum(30'd51), packDen(30'd100), packDiv(9'd162, 3'd0, 8'd6));
    check("R5 near miss computes", gotRate, model(64'd24000000, 9'd162, 30'd51, 30'd100, 3'd0, 8'd6));
  endtask

  task automatic t_fieldBits();
    logic [63:0] exp;
    exp = model(64'd19200000, 9'd77, 30'd333, 30'd1000, 3'd3, 8'd5);
    runCalc(64'd19200000, packNum(30'd333) | 32'h3, packDen(30'd1000) | 32'hC000_0000,
            packDiv(9'd77, 3'd3, 8'd5) | 32'hFE00_1F00);
    check("R1 reserved bits ignored", gotRate, exp);
  endtask

  task automatic t_wrap();
    logic [63:0] r;
    r = 64'h0000_0100_0000_3039;
    runCalc(r, packNum(30'd12345), packDen(30'h2000_0007), packDiv(9'd511, 3'd7, 8'd255));
    check("R2 wrapping arithmetic", gotRate, model(r, 9'd511, 30'd12345, 30'h2000_0007, 3'd7, 8'd255));
  endtask

  task automatic t_zeroDiv();
    runCalc(64'd24000000, packNum(30'd5), packDen(30'd0), packDiv(9'd10, 3'd0, 8'd4));
    check("R7 zero rate", gotRate, 64'd0);
    check("R7 err set", {63'd0, gotErr}, 64'd1);
    check("R7 err latency", 64'(gotLat), 64'(LAT_SHORT));
    runCalc(64'd24000000, packNum(30'd0), packDen(30'h2000_0000), packDiv(9'd10, 3'd0, 8'd8));
    check("R7 wrapped zero err", {63'd0, gotErr}, 64'd1);
    runCalc(64'd24000000, packNum(30'd0), packDen(30'd1), packDiv(9'd100, 3'd0, 8'd0));
    check("R7 err cleared", {63'd0, gotErr}, 64'd0);
  endtask

  task automatic t_busyIgnore();
    int lat;
    int extraDone;
    logic [63:0] expA;
    expA = model(64'd24000000, 9'd90, 30'd7, 30'd9, 3'd1, 8'd4);
    @(negedge clk);
    refRate = 64'd24000000; numWord = packNum(30'd7); denWord = packDen(30'd9);
    divWord = packDiv(9'd90, 3'd1, 8'd4); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    refRate = 64'd1; numWord = '0; denWord = '0; divWord = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat++;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check("R8 first result kept", rateOut, expA);
    check("R8 latency unchanged", 64'(lat), 64'(LAT_LONG));
    check("R8 no err from ignored start", {63'd0, divErr}, 64'd0);
    extraDone = 0;
    for (int k = 0; k < 80; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) extraDone++;
    end
    check("R8 no second done", 64'(extraDone), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_preset650();
    t_preset400();
    t_defaults();
    t_post1();
    t_fraction();
    t_fieldBits();
    t_wrap();
    t_zeroDiv();
    t_busyIgnore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule